// File: doc/BRIEF.md
# Dynamic Tagless Loop Cache Controller

This block sits next to the first-level instruction cache and a small instruction buffer. It watches the fetch stream and the branch outcome reported for each fetched word. When a short loop closes with a taken backward branch, it records the loop boundaries. On the next pass through the loop it copies every fetched word into the buffer. Once a complete pass has been captured and the same closing branch is taken again, later passes are served from the buffer and the first-level cache is no longer needed for them.

The buffer carries no tags and the controller never does a per-fetch lookup. Its state alone selects the instruction source, and it only serves a loop whose full body it has just captured, so a served fetch cannot miss. Program counters count instruction words. The index of a word in the buffer is its PC minus the recorded loop start. Any taken branch other than the loop's own closing branch, or a fall-through at the closing branch, returns the controller to idle. The following fetch is then taken from the first-level cache again.

Top module: `loop_buf_ctrl`

## Requirements
- R1: After a synchronous active-low reset the controller is idle: `use_buf` and `filling` are 0 and `insn_out` equals `fetch_insn`.
- R2: While idle, a valid fetch at PC P whose branch is taken with `br_short`=1 and target T, where T <= P and P-T < DEPTH, records T as loop start and P as loop end and sets `filling` to 1 from the next cycle.
- R3: While idle, a taken branch with P-T >= DEPTH, with T > P, or with `br_short`=0, and a not-taken branch with `br_short`=1, leave `filling` and `use_buf` at 0.
- R4: While filling, `use_buf` is 0 and `insn_out` equals `fetch_insn`. Each valid fetched word is written into the buffer at index PC minus loop start.
- R5: While filling, a valid fetch at the loop end whose branch is taken to the loop start sets `use_buf` to 1 from the next cycle. From then on `insn_out` returns the word captured at that PC, whatever `fetch_insn` carries.
- R6: While filling, a taken branch at any fetch that is not the closing branch clears `filling` from the next cycle, and `use_buf` stays 0.
- R7: While serving, a taken branch that is not the closing branch still has its own word served. `use_buf` is 0 from the next cycle.
- R8: While filling or serving, a not-taken branch at the loop end returns the controller to idle. The next fetch is taken from the first-level cache.
- R9: `use_buf` and `filling` are never 1 together, and `use_buf` rises only directly after a filling cycle.
- R10: A cycle with `fetch_valid`=0 changes no controller state and writes nothing into the buffer.
- R11: A loop with P-T = DEPTH-1 (body of exactly DEPTH words) is captured and served in full at every index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_valid | input | 1 | A fetch happens this cycle |
| fetch_pc | input | AW | Word address of the fetched instruction |
| fetch_insn | input | IW | Instruction word from the first-level cache |
| br_taken | input | 1 | The fetched instruction is a branch that is taken |
| br_short | input | 1 | The branch is flagged as a short backward branch |
| br_target | input | AW | Word address of the branch target |
| insn_out | output | IW | Instruction delivered to the core |
| use_buf | output | 1 | 1 when the loop buffer is the fetch source |
| filling | output | 1 | 1 while a loop pass is being captured |

## Verification
The source select is decoded straight from the controller state. A wrong state therefore shows on `use_buf` or `filling` in the same cycle as the first fetch after the faulty transition. An error in the recorded loop start or the buffer index leaves the select correct but shows as a wrong `insn_out` on the first served pass. The bench drives a junk word on `fetch_insn` during that pass so the error is exposed. A missed exit from serving shows on the first fetch after the branch that should have ended it, because that fetch still returns buffer content in place of the first-level word.

// File: rtl/loop_buf_pkg.sv
`timescale 1ns/1ps
// Shared types for the loop buffer controller.
// Assumes: nothing beyond a 2-bit state encoding.
package loop_buf_pkg;
    typedef enum logic [1:0] {
        LB_IDLE   = 2'd0,
        LB_FILL   = 2'd1,
        LB_SERVE  = 2'd2
    } lb_state_t;
endpackage

// File: rtl/loop_buf_store.sv
`timescale 1ns/1ps
// Loop body storage: one write port, one asynchronous read port.
// Assumes: the index is already reduced to the buffer range by the caller.
// Contents are undefined after reset; the controller never reads an unwritten entry.
module loop_buf_store #(
    parameter int DEPTH = 64,
    parameter int IW    = 32,
    localparam int IDXW = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            wr_en,
    input  logic [IDXW-1:0] idx,
    input  logic [IW-1:0]   wr_data,
    output logic [IW-1:0]   rd_data
);
    logic [IW-1:0] mem [DEPTH];

    // Capture one fetched word per fill cycle.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[idx] <= wr_data;
        end
    end

    // Serve the word stored for the current fetch.
    assign rd_data = mem[idx];
endmodule

// File: rtl/loop_buf_fsm.sv
`timescale 1ns/1ps
// Loop detection and sequencing: idle -> fill on a qualified short backward
// branch, fill -> serve when the same branch closes the loop again, and any
// other control-flow change back to idle.
// Assumes: PCs count instruction words; fetches within a loop pass are
// sequential unless a taken branch is reported.
module loop_buf_fsm
    import loop_buf_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = 32,
    localparam int IDXW = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fetch_valid,
    input  logic [AW-1:0]   fetch_pc,
    input  logic            br_taken,
    input  logic            br_short,
    input  logic [AW-1:0]   br_target,
    output logic            wr_en,
    output logic [IDXW-1:0] idx,
    output logic            filling,
    output logic            serving
);
    localparam logic [AW-1:0] DEPTH_A = AW'(DEPTH);

    lb_state_t     state, state_nx;
    logic [AW-1:0] loop_start, loop_end;
    logic [AW-1:0] back_dist;
    logic [AW-1:0] offset;
    logic          sbb_ok;
    logic          at_end;
    logic          closing;

    // Qualify a taken short backward branch that fits into the buffer.
    always_comb begin
        back_dist = fetch_pc - br_target;
        sbb_ok    = br_taken && br_short && (br_target <= fetch_pc)
                    && (back_dist < DEPTH_A);
    end

    // Recognise the recorded closing branch and the buffer index.
    always_comb begin
        at_end  = (fetch_pc == loop_end);
        closing = at_end && br_taken && (br_target == loop_start);
        offset  = fetch_pc - loop_start;
        idx     = offset[IDXW-1:0];
    end

    // Next-state decision for one valid fetch.
    always_comb begin
        state_nx = state;
        if (fetch_valid) begin
            unique case (state)
                LB_IDLE: begin
                    if (sbb_ok) state_nx = LB_FILL;
                end
                LB_FILL, LB_SERVE: begin
                    if (closing)             state_nx = LB_SERVE;
                    else if (br_taken)       state_nx = LB_IDLE;
                    else if (at_end)         state_nx = LB_IDLE;
                end
                default: state_nx = LB_IDLE;
            endcase
        end
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= LB_IDLE;
        else        state <= state_nx;
    end

    // Latch loop boundaries when a loop is first detected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loop_start <= '0;
            loop_end   <= '0;
        end else if (fetch_valid && state == LB_IDLE && sbb_ok) begin
            loop_start <= br_target;
            loop_end   <= fetch_pc;
        end
    end

    assign filling = (state == LB_FILL);
    assign serving = (state == LB_SERVE);
    assign wr_en   = fetch_valid && filling;

    AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        !(filling && serving)); // R9
    AST_SERVE_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(serving) |-> $past(filling)); // R9
    AST_FILL_NEEDS_SBB: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(filling) |-> $past(br_taken && br_short && fetch_valid)); // R2
    AST_FORWARD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LB_IDLE && br_target > fetch_pc) |=> !filling); // R3
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |=> $stable(state)); // R10
    AST_EXIT_ON_COF: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && filling && br_taken && !at_end) |=> !filling && !serving); // R6
endmodule

// File: rtl/loop_buf_ctrl.sv
`timescale 1ns/1ps
// Dynamic tagless loop cache controller top: loop sequencing, loop body
// storage and the fetch-source mux.
// Assumes: fetch_insn comes from the first-level cache for fetch_pc in the
// same cycle; branch information refers to the instruction at fetch_pc.
module loop_buf_ctrl #(
    parameter int DEPTH = 64,
    parameter int AW    = 32,
    parameter int IW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetch_valid,
    input  logic [AW-1:0] fetch_pc,
    input  logic [IW-1:0] fetch_insn,
    input  logic          br_taken,
    input  logic          br_short,
    input  logic [AW-1:0] br_target,
    output logic [IW-1:0] insn_out,
    output logic          use_buf,
    output logic          filling
);
    localparam int IDXW = $clog2(DEPTH);

    logic            wr_en;
    logic [IDXW-1:0] idx;
    logic            serving;
    logic [IW-1:0]   buf_word;

    loop_buf_fsm #(.DEPTH(DEPTH), .AW(AW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_valid (fetch_valid),
        .fetch_pc    (fetch_pc),
        .br_taken    (br_taken),
        .br_short    (br_short),
        .br_target   (br_target),
        .wr_en       (wr_en),
        .idx         (idx),
        .filling     (filling),
        .serving     (serving)
    );

    loop_buf_store #(.DEPTH(DEPTH), .IW(IW)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .idx     (idx),
        .wr_data (fetch_insn),
        .rd_data (buf_word)
    );

    // Fetch-source mux driven by controller state only.
    assign use_buf  = serving;
    assign insn_out = use_buf ? buf_word : fetch_insn;
endmodule

// File: tb/test_loop_buf_ctrl.sv
`timescale 1ns/1ps
module test_loop_buf_ctrl;
    localparam int DEPTH = 64;
    localparam logic [31:0] JUNK = 32'hDEAD_BEEF;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        fetch_valid;
    logic [31:0] fetch_pc;
    logic [31:0] fetch_insn;
    logic        br_taken;
    logic        br_short;
    logic [31:0] br_target;
    logic [31:0] insn_out;
    logic        use_buf;
    logic        filling;

    int n_chk  = 0;
    int n_fail = 0;

    loop_buf_ctrl #(.DEPTH(DEPTH), .AW(32), .IW(32)) i_loop_buf_ctrl (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid),
        .fetch_pc(fetch_pc), .fetch_insn(fetch_insn), .br_taken(br_taken),
        .br_short(br_short), .br_target(br_target), .insn_out(insn_out),
        .use_buf(use_buf), .filling(filling)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] l1_word(input logic [31:0] pc);
        return {pc[15:0] ^ 16'h5A3C, pc[15:0]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One fetch cycle: drive at negedge, sample outputs before the next edge.
    task automatic step(input logic v, input logic [31:0] pc, input logic [31:0] insn,
                        input logic tk, input logic sh, input logic [31:0] tgt,
                        input logic e_use, input logic e_fill,
                        input logic chk_out, input logic [31:0] e_out, input string tag);
        @(negedge clk);
        fetch_valid = v; fetch_pc = pc; fetch_insn = insn;
        br_taken = tk; br_short = sh; br_target = tgt;
        #1;
        chk({tag, " use_buf"}, {31'd0, use_buf}, {31'd0, e_use});
        chk({tag, " filling"}, {31'd0, filling}, {31'd0, e_fill});
        if (chk_out) chk({tag, " insn_out"}, insn_out, e_out);
        chk("R9 exclusive", {31'd0, use_buf & filling}, 32'd0);
    endtask

    // One pass over [s,e]; the last fetch carries the closing branch if tk.
    task automatic pass(input logic [31:0] s, input logic [31:0] e, input logic junk,
                        input logic tk, input logic e_use, input logic e_fill, input string tag);
        for (logic [31:0] pc = s; pc <= e; pc++) begin
            step(1'b1, pc, junk ? JUNK : l1_word(pc), (pc == e) && tk, (pc == e) && tk, s,
                 e_use, e_fill, 1'b1, l1_word(pc), tag);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; fetch_valid = 1'b0; fetch_pc = '0; fetch_insn = '0;
        br_taken = 1'b0; br_short = 1'b0; br_target = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        step(1'b1, 32'h50, l1_word(32'h50), 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1,
             l1_word(32'h50), "R1 reset state");
    endtask

    task automatic t_basic();
        do_reset();
        pass(32'h100, 32'h103, 1'b0, 1'b1, 1'b0, 1'b0, "R2 detect pass");
        pass(32'h100, 32'h103, 1'b0, 1'b1, 1'b0, 1'b1, "R4 fill pass");
        pass(32'h100, 32'h103, 1'b1, 1'b1, 1'b1, 1'b0, "R5 served pass");
        pass(32'h100, 32'h103, 1'b1, 1'b0, 1'b1, 1'b0, "R5 served last pass");
        step(1'b1, 32'h104, l1_word(32'h104), 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1,
             l1_word(32'h104), "R8 exit after fall-through");
    endtask

    task automatic t_not_short();
        do_reset();
        // distance DEPTH: too long
        step(1'b1, 32'h340, l1_word(32'h340), 1'b1, 1'b1, 32'h300, 1'b0, 1'b0, 1'b1,
             l1_word(32'h340), "R3 long branch");
        step(1'b1, 32'h300, l1_word(32'h300), 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1,
             l1_word(32'h300), "R3 after long branch");
        // forward target
        step(1'b1, 32'h10, l1_word(32'h10), 1'b1, 1'b1, 32'h20, 1'b0, 1'b0, 1'b1,
             l1_word(32'h10), "R3 forward branch");
        step(1'b1, 32'h20, l1_word(32'h20), 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1,
             l1_word(32'h20), "R3 after forward branch");
        // short flag low
        step(1'b1, 32'h44, l1_word(32'h44), 1'b1, 1'b0, 32'h40, 1'b0, 1'b0, 1'b1,
             l1_word(32'h44), "R3 unflagged branch");
        step(1'b1, 32'h40, l1_word(32'h40), 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1,
             l1_word(32'h40), "R3 after unflagged branch");
        // not taken
        step(1'b1, 32'h44, l1_word(32'h44), 1'b0, 1'b1, 32'h40, 1'b0, 1'b0, 1'b1,
             l1_word(32'h44), "R3 not-taken branch");
        step(1'b1, 32'h45, l1_word(32'h45), 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1,
             l1_word(32'h45), "R3 after not-taken branch");
    endtask

    task automatic t_cof_fill();
        do_reset();
        pass(32'h400, 32'h405, 1'b0, 1'b1, 1'b0, 1'b0, "R6 detect");
        step(1'b1, 32'h400, l1_word(32'h400), 1'b0, 1'b0, 32'h0, 1'b0, 1'b1, 1'b1,
             l1_word(32'h400), "R6 fill start");
        step(1'b1, 32'h401, l1_word(32'h401), 1'b1, 1'b0, 32'h403, 1'b0, 1'b1, 1'b1,
             l1_word(32'h401), "R6 inner branch");
        step(1'b1, 32'h403, l1_word(32'h403), 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1,
             l1_word(32'h403), "R6 fill ended");
        step(1'b1, 32'h405, l1_word(32'h405), 1'b1, 1'b1, 32'h400, 1'b0, 1'b0, 1'b1,
             l1_word(32'h405), "R6 closing after exit");
    endtask

    task automatic t_cof_serve();
        do_reset();
        pass(32'h500, 32'h503, 1'b0, 1'b1, 1'b0, 1'b0, "R7 detect");
        pass(32'h500, 32'h503, 1'b0, 1'b1, 1'b0, 1'b1, "R7 fill");
        step(1'b1, 32'h500, JUNK, 1'b0, 1'b0, 32'h0, 1'b1, 1'b0, 1'b1,
             l1_word(32'h500), "R7 served");
        step(1'b1, 32'h501, JUNK, 1'b1, 1'b0, 32'h900, 1'b1, 1'b0, 1'b1,
             l1_word(32'h501), "R7 branch word served");
        step(1'b1, 32'h900, l1_word(32'h900), 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1,
             l1_word(32'h900), "R7 back to first level");
    endtask

    task automatic t_fill_fallthrough();
        do_reset();
        pass(32'h600, 32'h602, 1'b0, 1'b1, 1'b0, 1'b0, "R8 detect");
        pass(32'h600, 32'h602, 1'b0, 1'b0, 1'b0, 1'b1, "R8 fill not closed");
        step(1'b1, 32'h603, l1_word(32'h603), 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1,
             l1_word(32'h603), "R8 idle after fill fall-through");
    endtask

    task automatic t_stall();
        do_reset();
        pass(32'h700, 32'h703, 1'b0, 1'b1, 1'b0, 1'b0, "R10 detect");
        step(1'b1, 32'h700, l1_word(32'h700), 1'b0, 1'b0, 32'h0, 1'b0, 1'b1, 1'b1,
             l1_word(32'h700), "R10 fill");
        for (int k = 0; k < 3; k++) begin
            step(1'b0, 32'h701, JUNK, 1'b1, 1'b1, 32'h0, 1'b0, 1'b1, 1'b0,
                 32'h0, "R10 stall holds");
        end
        for (logic [31:0] pc = 32'h701; pc <= 32'h703; pc++) begin
            step(1'b1, pc, l1_word(pc), pc == 32'h703, pc == 32'h703, 32'h700, 1'b0, 1'b1,
                 1'b1, l1_word(pc), "R10 fill resumes");
        end
        pass(32'h700, 32'h703, 1'b1, 1'b1, 1'b1, 1'b0, "R10 served unharmed");
    endtask

    task automatic t_depth();
        do_reset();
        pass(32'h200, 32'h23F, 1'b0, 1'b1, 1'b0, 1'b0, "R11 detect full depth");
        pass(32'h200, 32'h23F, 1'b0, 1'b1, 1'b0, 1'b1, "R11 fill full depth");
        pass(32'h200, 32'h23F, 1'b1, 1'b0, 1'b1, 1'b0, "R11 served full depth");
        do_reset();
        step(1'b1, 32'h240, l1_word(32'h240), 1'b1, 1'b1, 32'h200, 1'b0, 1'b0, 1'b1,
             l1_word(32'h240), "R11 one past depth");
        step(1'b1, 32'h200, l1_word(32'h200), 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1,
             l1_word(32'h200), "R11 one past depth rejected");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        t_reset();
        t_basic();
        t_not_short();
        t_cof_fill();
        t_cof_serve();
        t_fill_fallthrough();
        t_stall();
        t_depth();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule